// File: doc/BRIEF.md
# Receive Octet Deframer with Self-Synchronizing Descrambler

This block sits on the receive side of a serial converter link, after an external 10b-to-8b decoder. Each cycle it may take one decoded octet with a flag that marks a control character. The two comma characters set the frame boundary. Data octets can then go through a self-synchronizing descrambler for the polynomial 1 + x^14 + x^15. Pairs of octets are unpacked back into 12-bit samples, and the tail nibble of each pair supplies an out-of-range indication.

The descrambler history is filled from the received bit stream. It therefore locks onto the transmitter without any seed exchange and recovers by itself after a disturbance. A comma that arrives in the middle of a frame throws away the half-built sample and produces a one-cycle lost-alignment pulse.

Top module: `rx_deframer`

## Requirements
- R1: While reset is asserted, and after it is released, `smp_data`, `smp_oor`, `smp_valid` and `align_lost` are all 0.
- R2: A comma is an accepted octet with `in_ctrl`=1 and value 0xBC or 0xFC. Until the first comma arrives, data octets produce no sample. An octet with value 0xBC and `in_ctrl`=0 is ordinary data.
- R3: After a comma, the first data octet (A) is the high octet of a frame and the next one (B) completes it. The sample is {A[7:0], B[7:4]}. `smp_valid` is high for exactly one cycle, in the cycle after B is accepted, and the next frame then starts.
- R4: `smp_oor` equals B[3] (the top tail bit) when `cfg_oor_en`=1 while B is accepted, and 0 otherwise.
- R5: When `cfg_descr_en`=1, each data bit is processed most significant bit first. Each recovered bit is the received bit XOR the received bits 14 and 15 bit times earlier. When `cfg_descr_en`=0, octets pass through unchanged. In both modes the 15-bit history (reset to 0) loads every received data bit.
- R6: After any mismatch between the transmitter and receiver history, every bit that arrives 15 or more bit times later is recovered correctly. This means the second frame after the disturbance is exact.
- R7: A comma that arrives after the high octet of a frame discards that octet and sets `align_lost` for one cycle, in the cycle after the comma. A comma at a frame boundary leaves `align_lost` at 0. In both cases the next data octet is a high octet.
- R8: Control characters produce no sample and leave the descrambler history unchanged. A control character that is not a comma is ignored, and the frame in progress continues.
- R9: A cycle with `in_valid`=0 has no effect on alignment, history or outputs.
- R10: `smp_data` holds its last value in every cycle where `smp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An octet is presented this cycle |
| in_ctrl | input | 1 | The octet is a control character |
| in_octet | input | 8 | Decoded octet |
| cfg_descr_en | input | 1 | Enable descrambling |
| cfg_oor_en | input | 1 | Use the top tail bit as out-of-range |
| smp_data | output | 12 | Recovered sample |
| smp_oor | output | 1 | Out-of-range indication for the sample |
| smp_valid | output | 1 | One-cycle strobe per completed frame |
| align_lost | output | 1 | One-cycle pulse when a comma breaks a frame |

## Verification
Two functions can act in the same cycle: discarding a partial frame and realigning both happen on a single mid-frame comma. The bench provokes this by sending a 0xFC comma directly after a high octet, with descrambling active. It expects `align_lost` in the next cycle and no sample. It then expects the two following data octets to form an exact sample. A wrongly kept half-frame, or history polluted by the comma, would corrupt that sample.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;
  localparam int OCT_W  = 8;
  localparam int TAIL_W = 4;
  localparam int SMP_W  = 2 * OCT_W - TAIL_W;
  localparam int TAP_A  = 14;
  localparam int TAP_B  = 15;
  localparam int HIST_W = TAP_B;

  typedef struct packed {
    logic [HIST_W-1:0] hist;
    logic [OCT_W-1:0]  data;
  } dscr_res_t;

  // Bit-serial inverse of the 1 + x^14 + x^15 scrambler, MSB first.
  function automatic dscr_res_t dscr_octet(logic [HIST_W-1:0] h_in,
                                           logic [OCT_W-1:0] rx);
    dscr_res_t r;
    logic [HIST_W-1:0] h;
    r = '0;
    h = h_in;
    for (int i = OCT_W - 1; i >= 0; i--) begin
      r.data[i] = rx[i] ^ h[TAP_A-1] ^ h[TAP_B-1];
      h = {h[HIST_W-2:0], rx[i]};
    end
    r.hist = h;
    return r;
  endfunction

  function automatic logic is_comma(logic ctrl, logic [OCT_W-1:0] o,
                                    logic [OCT_W-1:0] ka, logic [OCT_W-1:0] kb);
    return ctrl && ((o == ka) || (o == kb));
  endfunction

  function automatic logic [SMP_W-1:0] unpack_sample(logic [OCT_W-1:0] hi,
                                                     logic [OCT_W-1:0] lo);
    return {hi, lo[OCT_W-1:TAIL_W]};
  endfunction
endpackage

// File: rtl/rxdf_descrambler.sv
module rxdf_descrambler
  import rxdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             en,
  input  logic [OCT_W-1:0] rx_octet,
  output logic [OCT_W-1:0] out_octet
);
  logic [HIST_W-1:0] hist_q;
  dscr_res_t         res;

  always_comb res = dscr_octet(hist_q, rx_octet);

  assign out_octet = en ? res.data : rx_octet;

  // History always follows the received stream, in both modes.
  always_ff @(posedge clk) begin
    if (!rst_n)    hist_q <= '0;
    else if (step) hist_q <= res.hist;
  end
endmodule

// File: rtl/rxdf_frame_tracker.sv
module rxdf_frame_tracker
  import rxdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comma_evt,
  input  logic             data_evt,
  input  logic [OCT_W-1:0] octet,
  output logic             emit,
  output logic             lost_evt,
  output logic [OCT_W-1:0] hi_octet
);
  logic aligned_q;
  logic phase_q;

  assign emit     = data_evt  & aligned_q & phase_q;
  assign lost_evt = comma_evt & aligned_q & phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      phase_q   <= 1'b0;
      hi_octet  <= '0;
    end else if (comma_evt) begin
      aligned_q <= 1'b1;
      phase_q   <= 1'b0;
    end else if (data_evt && aligned_q) begin
      phase_q <= ~phase_q;
      if (!phase_q) hi_octet <= octet;
    end
  end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rxdf_pkg::*;
#(
  parameter logic [OCT_W-1:0] COMMA_P = 8'hBC,
  parameter logic [OCT_W-1:0] COMMA_Q = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ctrl,
  input  logic [OCT_W-1:0] in_octet,
  input  logic             cfg_descr_en,
  input  logic             cfg_oor_en,
  output logic [SMP_W-1:0] smp_data,
  output logic             smp_oor,
  output logic             smp_valid,
  output logic             align_lost
);
  logic             comma_evt;
  logic             data_evt;
  logic             emit;
  logic             lost_evt;
  logic [OCT_W-1:0] plain_octet;
  logic [OCT_W-1:0] hi_octet;

  assign comma_evt = in_valid & is_comma(in_ctrl, in_octet, COMMA_P, COMMA_Q);
  assign data_evt  = in_valid & ~in_ctrl;

  rxdf_descrambler u_dscr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (data_evt),
    .en        (cfg_descr_en),
    .rx_octet  (in_octet),
    .out_octet (plain_octet)
  );

  rxdf_frame_tracker u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .comma_evt (comma_evt),
    .data_evt  (data_evt),
    .octet     (plain_octet),
    .emit      (emit),
    .lost_evt  (lost_evt),
    .hi_octet  (hi_octet)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_data   <= '0;
      smp_oor    <= 1'b0;
      smp_valid  <= 1'b0;
      align_lost <= 1'b0;
    end else begin
      smp_valid  <= emit;
      align_lost <= lost_evt;
      if (emit) begin
        smp_data <= unpack_sample(hi_octet, plain_octet);
        smp_oor  <= cfg_oor_en & plain_octet[TAIL_W-1];
      end
    end
  end
endmodule

// File: rtl/rxdf_checker.sv
module rxdf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic        smp_oor,
  input logic        align_lost,
  input logic        cfg_oor_en,
  input logic        comma_evt,
  input logic        data_evt,
  input logic [11:0] smp_data
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  a_r3_valid_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(data_evt));

  a_r7_lost_after_comma: assert property (@(posedge clk) disable iff (!rst_n)
    align_lost |-> $past(comma_evt));

  a_r8_comma_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    align_lost |-> !smp_valid);

  a_r4_oor_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_oor) |-> $past(cfg_oor_en));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data));
endmodule

bind rx_deframer rxdf_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_oor    (smp_oor),
  .align_lost (align_lost),
  .cfg_oor_en (cfg_oor_en),
  .comma_evt  (comma_evt),
  .data_evt   (data_evt),
  .smp_data   (smp_data)
);

// File: tb/rx_deframer_tb_top.sv
module rx_deframer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ctrl = 1'b0;
  logic [7:0]  in_octet = 8'h00;
  logic        cfg_descr_en = 1'b0;
  logic        cfg_oor_en = 1'b0;
  logic [11:0] smp_data;
  logic        smp_oor;
  logic        smp_valid;
  logic        align_lost;

  always #4 clk = ~clk;

  rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_octet(in_octet), .cfg_descr_en(cfg_descr_en), .cfg_oor_en(cfg_oor_en),
    .smp_data(smp_data), .smp_oor(smp_oor), .smp_valid(smp_valid),
    .align_lost(align_lost)
  );

  typedef struct { logic [11:0] smp; logic oor; bit dc; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  int n_checks = 0;
  int n_fail = 0;
  bit mon_on = 0;
  logic exp_valid = 1'b0;
  logic exp_lost = 1'b0;
  logic [11:0] last_data = '0;

  // bench model state
  bit        tb_aligned = 0;
  bit        tb_phase = 0;
  bit        scr_en = 0;
  logic [14:0] tx_hist = '0;
  logic [7:0]  tb_hi = '0;
  bit        dc_next = 0;
  string     cur_tag = "R3";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // transmitter-side scrambler: history holds transmitted bits
  function automatic logic [7:0] scramble(input logic [7:0] d);
    logic [7:0] t;
    for (int b = 7; b >= 0; b--) begin
      t[b] = scr_en ? (d[b] ^ tx_hist[13] ^ tx_hist[14]) : d[b];
      tx_hist = {tx_hist[13:0], t[b]};
    end
    return t;
  endfunction

  task automatic drive(input logic v, input logic c, input logic [7:0] o,
                       input logic lost_p, input logic valid_p);
    @(negedge clk);
    in_valid = v; in_ctrl = c; in_octet = o;
    @(posedge clk);
    #1;
    exp_lost = lost_p;
    exp_valid = valid_p;
  endtask

  task automatic send_data(input logic [7:0] d);
    logic [7:0] tx;
    exp_t x;
    tx = scramble(d);
    if (!tb_aligned) drive(1, 0, tx, 0, 0);
    else if (!tb_phase) begin
      tb_hi = d; tb_phase = 1;
      drive(1, 0, tx, 0, 0);
    end else begin
      x.smp = {tb_hi, d[7:4]};
      x.oor = cfg_oor_en & d[3];
      x.dc = dc_next;
      x.tag = cur_tag;
      dc_next = 0;
      q.push_back(x);
      tb_phase = 0;
      drive(1, 0, tx, 0, 1);
    end
  endtask

  task automatic send_frame(input logic [11:0] s, input logic [3:0] tail);
    send_data(s[11:4]);
    send_data({s[3:0], tail});
  endtask

  task automatic send_comma(input logic [7:0] k);
    logic lost;
    lost = tb_aligned && tb_phase;
    tb_aligned = 1; tb_phase = 0;
    drive(1, 1, k, lost, 0);
  endtask

  task automatic send_ctrl(input logic [7:0] o);
    drive(1, 1, o, 0, 0);
  endtask

  task automatic idle();
    drive(0, 0, 8'hBC, 0, 0);
  endtask

  // monitor: compares strobes every cycle, pops scoreboard on samples
  always @(negedge clk) begin
    if (mon_on) begin
      check("R3 valid strobe", smp_valid, exp_valid);
      check("R7 align_lost", align_lost, exp_lost);
      if (smp_valid) begin
        if (q.size() == 0) check("R3 unexpected sample", 1, 0);
        else begin
          e = q.pop_front();
          if (!e.dc) begin
            check({e.tag, " sample"}, smp_data, e.smp);
            check({e.tag, " oor"}, smp_oor, e.oor);
          end
        end
        last_data = smp_data;
      end else begin
        check("R10 hold", smp_data, last_data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 smp_data", smp_data, 0);
    check("R1 smp_oor", smp_oor, 0);
    check("R1 smp_valid", smp_valid, 0);
    check("R1 align_lost", align_lost, 0);
    rst_n = 1'b1;
    mon_on = 1;

    // R2: no samples before first comma; 0xBC without ctrl is data
    cfg_oor_en = 1;
    send_data(8'h12); send_data(8'h34); send_data(8'hBC); send_data(8'h56);
    idle();

    // R3/R4: plain frames
    cur_tag = "R3";
    send_comma(8'hBC);
    send_frame(12'hFFF, 4'h8);
    send_frame(12'h000, 4'h0);
    send_frame(12'hA5C, 4'h7);
    cur_tag = "R4";
    send_frame(12'h3C1, 4'hF);
    cfg_oor_en = 0;
    send_frame(12'hFFF, 4'h8);
    send_frame(12'h7E3, 4'hC);
    cfg_oor_en = 1;

    // R5: descrambling on both sides
    scr_en = 1; cfg_descr_en = 1;
    cur_tag = "R5";
    for (int i = 0; i < 10; i++) send_frame(12'(i * 12'h2B7 + 12'h135), 4'(i * 5));

    // R8: non-comma control mid-frame ignored
    cur_tag = "R8";
    send_data(8'h9A); send_ctrl(8'h1C); send_data(8'h4B);
    send_frame(12'h5D2, 4'h9);

    // R9: idle mid-frame
    cur_tag = "R9";
    send_data(8'hC3); idle(); idle(); send_data(8'h68);
    send_frame(12'h0F1, 4'h3);

    // R7: mid-frame comma, then boundary comma, then back-to-back
    cur_tag = "R7";
    send_data(8'hEE); send_comma(8'hFC);
    send_frame(12'h8A4, 4'h8);
    send_comma(8'hBC);
    send_frame(12'h129, 4'h1);
    send_data(8'h77); send_comma(8'hBC); send_comma(8'hFC);
    send_frame(12'hB3E, 4'hA);

    // R6: history disturbance, first frame don't-care, then exact
    cur_tag = "R6";
    tx_hist = tx_hist ^ 15'h5A3C;
    dc_next = 1;
    send_frame(12'h444, 4'h2);
    for (int i = 0; i < 4; i++) send_frame(12'(i * 12'h611 + 12'h0AB), 4'(i + 8));

    // R5: back to pass-through
    cur_tag = "R5";
    scr_en = 0; cfg_descr_en = 0;
    send_frame(12'hC0D, 4'hE);
    send_frame(12'h246, 4'h0);

    repeat (4) idle();
    check("R3 queue drained", q.size(), 0);
    finish_run();
  end
endmodule